// File: doc/BRIEF.md
# Polling Receiver Wake-Up Controller

This block duty-cycles a low-power radio receiver. Most of the time the receiver's signal chain is switched off while a timer counts out a programmable sleep period. When the timer expires, the signal chain is powered, given a start-up delay to settle, and then the demodulated bit stream is timed. A few well-formed bit intervals show that a real transmitter is present. In that case the controller latches the receiver on and forwards the data to the host. Otherwise it drops straight back to sleep.

Software configuration is applied as static input fields:
- a 5-bit sleep word,
- a 2-bit extension factor,
- a 2-bit baud range,
- the number of bit intervals to qualify.

The baud range sets the length of a half-bit tick. Both the start-up delay and the interval limits are expressed in that tick. A host ends a reception with an off command.

Top module: `poll_wake_ctrl`

## Requirements
- R1: The mode output follows sleep (0) → start-up (1) → bit-check (2) → receiving (3). Sleep is left only for start-up. Start-up is left only for bit-check. Bit-check is left for receiving or sleep. Receiving is left only for sleep.
- R2: In sleep, `rx_en` and `active` are both 0.
- R3: A sleep period lasts `sleep_word` × (`sleep_ext` + 1) × `SLEEP_UNIT` clock cycles. A `sleep_word` of 0 gives exactly one `SLEEP_UNIT`, whatever `sleep_ext` holds.
- R4: Start-up holds `rx_en` at 1 and lasts `STARTUP_HB` half-bit ticks. One tick lasts `HB_BASE << baud_sel` clock cycles.
- R5: In bit-check, the first edge of `din` starts timing. Each following edge closes one interval, measured in whole ticks. After `bit_count` intervals (0 counts as 1), each of at least `LO_HB` ticks, the block enters receiving. An interval shorter than `LO_HB` ticks returns it to sleep at once.
- R6: In bit-check, if no edge arrives within `HI_HB + baud_sel` ticks, the block returns to sleep. This applies both before the first edge and between edges, so an interval longer than that limit fails.
- R7: In receiving, `active` and `rx_en` are 1 and `data_out` follows `din` one cycle late. An off command takes the block to sleep on the next cycle.
- R8: Outside receiving, `data_out` is 0 and `off_cmd` has no effect.
- R9: A synchronous reset puts the block in sleep with all counters cleared, so the next sleep period is full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Basic clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Demodulated data stream |
| off_cmd | input | 1 | Ends a reception |
| sleep_word | input | 5 | Sleep length in units of SLEEP_UNIT clocks |
| sleep_ext | input | 2 | Sleep extension, factor = value + 1 |
| baud_sel | input | 2 | Baud range, scales the half-bit tick |
| bit_count | input | 3 | Intervals to qualify before receiving |
| rx_en | output | 1 | Signal-processing enable |
| active | output | 1 | High while receiving |
| data_out | output | 1 | Gated data to the host |
| mode | output | 2 | Current mode code |

## Verification
The embedded properties check, on every cycle, several rules:
- the legal mode successions;
- that the sleep unit counter never passes its target;
- that the interval counter never exceeds the upper limit while checking;
- that an off command in receiving always leads to sleep.

Exact durations need the bench's scenarios. These cover sleep lengths for zero and scaled words, and start-up length per baud range. They also cover acceptance or rejection of edge patterns exactly at both interval limits, and the no-edge timeout. Gating of data and the off command, and recovery from a mid-reception reset, are likewise shown only by scenarios.

// File: rtl/poll_wake_ctrl.sv
module poll_wake_ctrl #(
  parameter int SLEEP_UNIT = 1024,
  parameter int HB_BASE    = 4,
  parameter int STARTUP_HB = 8,
  parameter int LO_HB      = 3,
  parameter int HI_HB      = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       din,
  input  logic       off_cmd,
  input  logic [4:0] sleep_word,
  input  logic [1:0] sleep_ext,
  input  logic [1:0] baud_sel,
  input  logic [2:0] bit_count,
  output logic       rx_en,
  output logic       active,
  output logic       data_out,
  output logic [1:0] mode
);

  localparam int UW = $clog2(SLEEP_UNIT);
  localparam int PW = $clog2(HB_BASE * 8) + 1;
  localparam int SW = $clog2(STARTUP_HB) + 1;
  localparam int IW = $clog2(HI_HB + 4) + 1;

  typedef enum logic [1:0] {SLEEP = 2'd0, STARTUP = 2'd1, BITCHK = 2'd2, RECV = 2'd3} mode_t;

  mode_t          st;
  logic [UW-1:0]  unit_cnt;
  logic [7:0]     slp_units;
  logic [PW-1:0]  pre;
  logic [SW-1:0]  su_cnt;
  logic [IW-1:0]  iv;
  logic [3:0]     bits_ok;
  logic           started;
  logic           d1, d2;

  logic [7:0]     slp_target;
  logic [PW-1:0]  hb_last;
  logic [IW-1:0]  lo_lim, hi_lim;
  logic [3:0]     need;
  logic           tick, edge_seen;

  assign slp_target = (sleep_word == 5'd0) ? 8'd1 : 8'(sleep_word) * (8'(sleep_ext) + 8'd1);
  assign hb_last    = (PW'(HB_BASE) << baud_sel) - PW'(1);
  assign lo_lim     = IW'(LO_HB);
  assign hi_lim     = IW'(HI_HB) + IW'(baud_sel);
  assign need       = (bit_count == 3'd0) ? 4'd1 : {1'b0, bit_count};
  assign tick       = (pre == hb_last);
  assign edge_seen  = (d1 != d2);

  assign mode     = st;
  assign rx_en    = (st != SLEEP);
  assign active   = (st == RECV);
  assign data_out = active & d1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SLEEP;
      unit_cnt  <= '0;
      slp_units <= '0;
      pre       <= '0;
      su_cnt    <= '0;
      iv        <= '0;
      bits_ok   <= '0;
      started   <= 1'b0;
      d1        <= 1'b0;
      d2        <= 1'b0;
    end else begin
      d1 <= din;
      d2 <= d1;
      case (st)
        SLEEP: begin
          if (unit_cnt == UW'(SLEEP_UNIT - 1)) begin
            unit_cnt <= '0;
            if (slp_units == slp_target - 8'd1) begin
              slp_units <= '0;
              st        <= STARTUP;
              pre       <= '0;
              su_cnt    <= '0;
            end else begin
              slp_units <= slp_units + 8'd1;
            end
          end else begin
            unit_cnt <= unit_cnt + UW'(1);
          end
        end
        STARTUP: begin
          if (tick) begin
            pre <= '0;
            if (su_cnt == SW'(STARTUP_HB - 1)) begin
              su_cnt  <= '0;
              st      <= BITCHK;
              iv      <= '0;
              bits_ok <= '0;
              started <= 1'b0;
            end else begin
              su_cnt <= su_cnt + SW'(1);
            end
          end else begin
            pre <= pre + PW'(1);
          end
        end
        BITCHK: begin
          if (edge_seen) begin
            pre <= PW'(1);
            iv  <= '0;
            if (!started) begin
              started <= 1'b1;
            end else if (iv < lo_lim) begin
              st        <= SLEEP;
              unit_cnt  <= '0;
              slp_units <= '0;
              bits_ok   <= '0;
              started   <= 1'b0;
            end else if (bits_ok == need - 4'd1) begin
              st      <= RECV;
              bits_ok <= '0;
              started <= 1'b0;
            end else begin
              bits_ok <= bits_ok + 4'd1;
            end
          end else if (tick) begin
            pre <= '0;
            if (iv == hi_lim) begin
              st        <= SLEEP;
              unit_cnt  <= '0;
              slp_units <= '0;
              iv        <= '0;
              bits_ok   <= '0;
              started   <= 1'b0;
            end else begin
              iv <= iv + IW'(1);
            end
          end else begin
            pre <= pre + PW'(1);
          end
        end
        RECV: begin
          if (off_cmd) begin
            st        <= SLEEP;
            unit_cnt  <= '0;
            slp_units <= '0;
            pre       <= '0;
            iv        <= '0;
          end
        end
        default: st <= SLEEP;
      endcase
    end
  end

  a_r1_leave_sleep: assert property (@(posedge clk) disable iff (rst)
    (st == SLEEP) |=> (st == SLEEP || st == STARTUP));

  a_r4_leave_startup: assert property (@(posedge clk) disable iff (rst)
    (st == STARTUP) |=> (st == STARTUP || st == BITCHK));

  a_r5_leave_check: assert property (@(posedge clk) disable iff (rst)
    (st == BITCHK) |=> (st != STARTUP));

  a_r6_interval_cap: assert property (@(posedge clk) disable iff (rst)
    (st == BITCHK) |-> (iv <= hi_lim));

  a_r3_units_bound: assert property (@(posedge clk) disable iff (rst)
    (st == SLEEP) |-> (slp_units < slp_target));

  a_r7_off_to_sleep: assert property (@(posedge clk) disable iff (rst)
    (st == RECV && off_cmd) |=> (st == SLEEP));

  a_r7_hold_recv: assert property (@(posedge clk) disable iff (rst)
    (st == RECV && !off_cmd) |=> (st == RECV));

endmodule

// File: tb/poll_wake_ctrl_test.sv
`timescale 1ns/1ps
module poll_wake_ctrl_test;
  logic clk = 1'b0, rst = 1'b1, din = 1'b0, off_cmd = 1'b0;
  logic [4:0] sleep_word = 5'd0;
  logic [1:0] sleep_ext = 2'd3, baud_sel = 2'd0;
  logic [2:0] bit_count = 3'd3;
  logic rx_en, active, data_out;
  logic [1:0] mode;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  poll_wake_ctrl uut (
    .clk(clk), .rst(rst), .din(din), .off_cmd(off_cmd),
    .sleep_word(sleep_word), .sleep_ext(sleep_ext), .baud_sel(baud_sel),
    .bit_count(bit_count), .rx_en(rx_en), .active(active),
    .data_out(data_out), .mode(mode)
  );

  // {expect_recv, baud, bits, k0, k1, k2, k3}; limits lo=3, hi=5+baud, tick=4<<baud clocks
  localparam logic [21:0] VECS [0:7] = '{
    {1'b1, 2'd0, 3'd3, 4'd4, 4'd4, 4'd4, 4'd0},
    {1'b1, 2'd0, 3'd3, 4'd3, 4'd5, 4'd3, 4'd0},
    {1'b0, 2'd0, 3'd3, 4'd4, 4'd2, 4'd4, 4'd0},
    {1'b0, 2'd0, 3'd3, 4'd4, 4'd6, 4'd4, 4'd0},
    {1'b1, 2'd1, 3'd3, 4'd6, 4'd6, 4'd6, 4'd0},
    {1'b1, 2'd3, 3'd2, 4'd8, 4'd3, 4'd0, 4'd0},
    {1'b1, 2'd2, 3'd1, 4'd7, 4'd0, 4'd0, 4'd0},
    {1'b0, 2'd2, 3'd4, 4'd4, 4'd4, 4'd4, 4'd8}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_mode(input logic [1:0] m);
    for (int i = 0; i < 20000 && mode != m; i++) @(negedge clk);
  endtask

  task automatic count_mode(input logic [1:0] m, output int n);
    n = 0;
    while (mode == m && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R9 reset mode", mode, 0);
    chk("R2 reset rx_en", rx_en, 0);
    chk("R2 reset active", active, 0);
    chk("R8 reset data_out", data_out, 0);
    rst = 1'b0;
    count_mode(2'd0, n);
    chk("R3 zero word sleep length", n, 1024);
    chk("R4 startup rx_en", rx_en, 1);
    count_mode(2'd1, n);
    chk("R4 startup length baud0", n, 32);
    chk("R1 startup to bitcheck", mode, 2);
    sleep_word = 5'd2; sleep_ext = 2'd1;
    count_mode(2'd2, n);
    chk("R6 no-edge timeout to sleep", mode, 0);
    chk("R2 sleep active", active, 0);
    baud_sel = 2'd2;
    count_mode(2'd0, n);
    chk("R3 scaled sleep length", n, 4096);
    count_mode(2'd1, n);
    chk("R4 startup length baud2", n, 128);
    sleep_word = 5'd1; sleep_ext = 2'd0;
    wait_mode(2'd0);

    foreach (VECS[v]) begin
      logic [21:0] e = VECS[v];
      int per = 4 << e[20:19];
      baud_sel = e[20:19];
      bit_count = e[18:16];
      wait_mode(2'd2);
      din = ~din;
      for (int i = 0; i < int'(e[18:16]); i++) begin
        repeat (int'(e[15-4*i -: 4]) * per) @(negedge clk);
        din = ~din;
      end
      repeat (3) @(negedge clk);
      chk($sformatf("R5 vector %0d end mode", v), mode, e[21] ? 3 : 0);
      if (e[21]) begin
        chk("R7 active in receive", active, 1);
        din = ~din;
        @(negedge clk);
        chk("R7 data follows", data_out, din);
        din = ~din;
        @(negedge clk);
        chk("R7 data follows again", data_out, din);
        off_cmd = 1'b1;
        @(negedge clk);
        off_cmd = 1'b0;
        chk("R7 off to sleep", mode, 0);
      end
    end

    baud_sel = 2'd0; bit_count = 3'd0;
    wait_mode(2'd2);
    off_cmd = 1'b1;
    din = ~din;
    @(negedge clk);
    @(negedge clk);
    chk("R8 data gated in bitcheck", data_out, 0);
    chk("R8 off ignored in bitcheck", mode, 2);
    off_cmd = 1'b0;
    repeat (16) @(negedge clk);
    din = ~din;
    repeat (3) @(negedge clk);
    chk("R5 zero count means one interval", mode, 3);

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 reset from receive", mode, 0);
    chk("R9 reset clears active", active, 0);
    count_mode(2'd0, n);
    chk("R9 full sleep after reset", n, 1024);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule